// File: doc/BRIEF.md
# Serial Receive Queue with Threshold Flags

This block is the receive-side byte queue of a serial controller. A deserializer strobes completed bytes into it. The processor or a DMA engine removes bytes through a data-register read. The queue keeps a running occupancy count and three status flags: a threshold-reached flag, a data-waiting flag and an overrun flag. From these it drives a receive interrupt request, an error interrupt request and a one-cycle DMA request.

The threshold is chosen by a 2-bit selector. A per-frame tick lets the block detect a queue that holds a few bytes below the threshold while the line has gone quiet. Only then is the data-waiting flag raised. A DMA pop clears the flags by itself. A processor pop leaves them alone, so software must clear them through the clear-request inputs. A clear request is refused while its condition still holds.

An overflow throws away the incoming byte and stops all further reception until software clears the overrun flag.

Top module: `serial_rx_queue`

## Requirements
- R1: Stored bytes leave in arrival order. `count` always equals the number of stored bytes and never exceeds 16. A strobe into a full queue is still stored when a pop happens in the same cycle.
- R2: `trig_sel` sets the threshold: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. After a byte is stored, if the new count is at or above the threshold, then in the next cycle `full_flag` is set and `dma_req` is high for exactly one cycle.
- R3: A strobe into a queue holding 16 bytes, with no pop in that cycle, discards the byte and sets `ovr_flag`.
- R4: An overflow raises `err_irq` when `rie` or `eie` is set. `err_irq` falls when `ovr_flag` clears or when both enables are low.
- R5: While `ovr_flag` is set or `rx_en` is low, strobes are ignored and `count` does not rise.
- R6: On a `frame_tick`, `ready_flag` sets if all of these hold: the queue is non-empty, it is below the threshold, and no strobe was accepted since the previous tick or in the frame before that. The same event pulses `dma_req`.
- R7: A DMA pop that leaves the count below the threshold clears `full_flag`. If it empties the queue, it also clears `ready_flag`. A processor pop changes no flag.
- R8: Setting `full_flag` or `ready_flag` raises `rx_irq` when `rie` is high. `rx_irq` is low whenever both flags are clear or `rie` is low.
- R9: `fifo_clr` empties the queue, zeroes `count` and clears `full_flag`, `ready_flag` and `rx_irq` on the next cycle.
- R10: A pop from an empty queue shows `pop_data` as zero and changes no state.
- R11: `full_clr` has no effect while the count is at or above the threshold. `ready_clr` has no effect while the queue is non-empty. `ovr_clr` always clears `ovr_flag` and lets reception resume.
- R12: After reset, the queue is empty and every flag and request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe from the deserializer |
| rx_data | input | DATA_W | Received byte |
| rx_en | input | 1 | Receive enable |
| trig_sel | input | 2 | Threshold selector |
| fifo_clr | input | 1 | Queue reset request |
| frame_tick | input | 1 | One pulse per frame time |
| pop_cpu | input | 1 | Processor data-register read |
| pop_dma | input | 1 | DMA data-register read |
| full_clr | input | 1 | Request to clear the threshold flag |
| ready_clr | input | 1 | Request to clear the data-waiting flag |
| ovr_clr | input | 1 | Request to clear the overrun flag |
| rie | input | 1 | Receive interrupt enable |
| eie | input | 1 | Error interrupt enable |
| pop_data | output | DATA_W | Byte at the head of the queue, zero when empty |
| count | output | CNT_W | Occupancy count |
| full_flag | output | 1 | Threshold reached |
| ready_flag | output | 1 | Data waiting below threshold on an idle line |
| ovr_flag | output | 1 | Overrun occurred |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The hardest state to reach is the data-waiting flag. It needs a partly filled queue below the threshold, and then two whole frames in which no strobe was accepted. The stimulus covers three cases: a strobe landing in the same cycle as a tick, a strobe between ticks, and a quiet line. This shows that the flag appears only on the third tick after the last byte. Overflow is reached by filling all 16 entries under each threshold setting. A strobe is then sent while frozen to show that the byte is dropped, followed by a push and a pop in the same cycle at full occupancy.

// File: rtl/srq_pkg.sv
package srq_pkg;

    localparam int unsigned SEL_W = 2;

    // Threshold picked by the 2-bit selector
    function automatic int unsigned trig_level(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    typedef struct packed {
        logic full;
        logic ready;
        logic ovr;
        logic rx_irq;
        logic err_irq;
        logic dma;
        logic win;   // strobe accepted since the last tick
        logic prev;  // strobe accepted in the frame before that
    } flag_state_t;

endpackage

// File: rtl/srq_store.sv
module srq_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  count_nx_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_q, st_d;
    logic [DATA_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (wr_en) st_d.tail = bump(st_q.tail);
            if (rd_en) st_d.head = bump(st_q.head);
            st_d.count = st_q.count + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) mem_q[st_q.tail] <= wdata;
    end

    assign rdata      = (st_q.count == '0) ? '0 : mem_q[st_q.head];
    assign count_o    = st_q.count;
    assign count_nx_o = st_d.count;

endmodule

// File: rtl/srq_flags.sv
module srq_flags
    import srq_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push_try,
    input  logic             push_ok,
    input  logic             overflow,
    input  logic             dma_pop,
    input  logic             tick,
    input  logic             full_clr,
    input  logic             ready_clr,
    input  logic             ovr_clr,
    input  logic             rie,
    input  logic             eie,
    input  logic [CNT_W-1:0] count_nx,
    input  logic [CNT_W-1:0] level,
    output logic             full_o,
    output logic             ready_o,
    output logic             ovr_o,
    output logic             rx_irq_o,
    output logic             err_irq_o,
    output logic             dma_o
);

    flag_state_t st_q, st_d;

    always_comb begin
        logic raise;
        logic below;
        logic empty_nx;
        logic err_en;
        logic seen;

        st_d     = st_q;
        st_d.dma = 1'b0;
        raise    = 1'b0;
        below    = (count_nx < level);
        empty_nx = (count_nx == '0);
        err_en   = rie | eie;
        seen     = st_q.win | push_try;

        if (clr) begin
            st_d.full  = 1'b0;
            st_d.ready = 1'b0;
        end else begin
            if (push_ok && !below) begin
                st_d.full = 1'b1;
                st_d.dma  = 1'b1;
                raise     = 1'b1;
            end
            if (dma_pop && below) begin
                st_d.full = 1'b0;
                if (empty_nx) st_d.ready = 1'b0;
            end
            if (full_clr && below)     st_d.full  = 1'b0;
            if (ready_clr && empty_nx) st_d.ready = 1'b0;
            if (tick && !seen && !st_q.prev && !empty_nx && below && !st_d.ready) begin
                st_d.ready = 1'b1;
                st_d.dma   = 1'b1;
                raise      = 1'b1;
            end
        end

        st_d.ovr = (st_q.ovr & ~ovr_clr) | overflow;

        if (tick) begin
            st_d.prev = seen;
            st_d.win  = 1'b0;
        end else begin
            st_d.win  = seen;
        end

        st_d.rx_irq  = (st_q.rx_irq | (raise & rie)) & (st_d.full | st_d.ready) & rie;
        st_d.err_irq = (st_q.err_irq | (overflow & err_en)) & st_d.ovr & err_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o    = st_q.full;
    assign ready_o   = st_q.ready;
    assign ovr_o     = st_q.ovr;
    assign rx_irq_o  = st_q.rx_irq;
    assign err_irq_o = st_q.err_irq;
    assign dma_o     = st_q.dma;

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import srq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_en,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              fifo_clr,
    input  logic              frame_tick,
    input  logic              pop_cpu,
    input  logic              pop_dma,
    input  logic              full_clr,
    input  logic              ready_clr,
    input  logic              ovr_clr,
    input  logic              rie,
    input  logic              eie,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              full_flag,
    output logic              ready_flag,
    output logic              ovr_flag,
    output logic              rx_irq,
    output logic              err_irq,
    output logic              dma_req
);

    logic [CNT_W-1:0] count_nx;
    logic [CNT_W-1:0] level;
    logic             rd_ok;
    logic             push_try;
    logic             push_ok;
    logic             overflow;

    always_comb begin
        if (trig_level(trig_sel) > DEPTH) level = CNT_W'(DEPTH);
        else                              level = CNT_W'(trig_level(trig_sel));
    end

    assign rd_ok    = (pop_cpu | pop_dma) && (count != '0) && !fifo_clr;
    assign push_try = rx_valid && rx_en && !ovr_flag && !fifo_clr;
    assign push_ok  = push_try && ((count < CNT_W'(DEPTH)) || rd_ok);
    assign overflow = push_try && !push_ok;

    srq_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .wr_en      (push_ok),
        .rd_en      (rd_ok),
        .wdata      (rx_data),
        .rdata      (pop_data),
        .count_o    (count),
        .count_nx_o (count_nx)
    );

    srq_flags #(
        .CNT_W (CNT_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push_try  (push_try),
        .push_ok   (push_ok),
        .overflow  (overflow),
        .dma_pop   (rd_ok & pop_dma),
        .tick      (frame_tick),
        .full_clr  (full_clr),
        .ready_clr (ready_clr),
        .ovr_clr   (ovr_clr),
        .rie       (rie),
        .eie       (eie),
        .count_nx  (count_nx),
        .level     (level),
        .full_o    (full_flag),
        .ready_o   (ready_flag),
        .ovr_o     (ovr_flag),
        .rx_irq_o  (rx_irq),
        .err_irq_o (err_irq),
        .dma_o     (dma_req)
    );

endmodule

// File: rtl/srq_chk.sv
module srq_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_clr,
    input logic             ovr_clr,
    input logic [CNT_W-1:0] count,
    input logic             full_flag,
    input logic             ready_flag,
    input logic             ovr_flag,
    input logic             rx_irq,
    input logic             err_irq,
    input logic             dma_req
);

    // R1
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R9
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (count == '0) && !full_flag && !ready_flag && !rx_irq);

    // R8
    rx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (full_flag || ready_flag));

    // R4
    err_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ovr_flag);

    // R11
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R5
    frozen_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> count <= $past(count));

    // R2
    dma_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (full_flag || ready_flag));

endmodule

bind serial_rx_queue srq_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_clr   (fifo_clr),
    .ovr_clr    (ovr_clr),
    .count      (count),
    .full_flag  (full_flag),
    .ready_flag (ready_flag),
    .ovr_flag   (ovr_flag),
    .rx_irq     (rx_irq),
    .err_irq    (err_irq),
    .dma_req    (dma_req)
);

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, rx_en, fifo_clr, frame_tick, pop_cpu, pop_dma;
    logic       full_clr, ready_clr, ovr_clr, rie, eie;
    logic [7:0] rx_data;
    logic [1:0] trig_sel;
    logic [7:0] pop_data;
    logic [4:0] count;
    logic       full_flag, ready_flag, ovr_flag, rx_irq, err_irq, dma_req;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string cur_req = "R12";

    // reference state
    byte unsigned mq[$];
    bit m_full, m_ready, m_ovr, m_rirq, m_eirq, m_dma, m_win, m_prev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_rx_queue u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_en(rx_en), .trig_sel(trig_sel), .fifo_clr(fifo_clr),
        .frame_tick(frame_tick), .pop_cpu(pop_cpu), .pop_dma(pop_dma),
        .full_clr(full_clr), .ready_clr(ready_clr), .ovr_clr(ovr_clr),
        .rie(rie), .eie(eie), .pop_data(pop_data), .count(count),
        .full_flag(full_flag), .ready_flag(ready_flag), .ovr_flag(ovr_flag),
        .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req)
    );

    function automatic int lvl(input int s);
        case (s)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("count", int'(count), mq.size());
        chk("full_flag", int'(full_flag), int'(m_full));
        chk("ready_flag", int'(ready_flag), int'(m_ready));
        chk("ovr_flag", int'(ovr_flag), int'(m_ovr));
        chk("rx_irq", int'(rx_irq), int'(m_rirq));
        chk("err_irq", int'(err_irq), int'(m_eirq));
        chk("dma_req", int'(dma_req), int'(m_dma));
    endtask

    task automatic release_pulses();
        rx_valid = 0; fifo_clr = 0; frame_tick = 0; pop_cpu = 0; pop_dma = 0;
        full_clr = 0; ready_clr = 0; ovr_clr = 0;
    endtask

    task automatic step();
        int trig, n, n2;
        bit rd, tr, ok, raise, everr, seen, en;
        if (pop_cpu || pop_dma)
            chk("pop_data", int'(pop_data), (mq.size() > 0) ? int'(mq[0]) : 0);
        @(posedge clk);
        trig = lvl(int'(trig_sel));
        n = mq.size();
        m_dma = 0; raise = 0; everr = 0; rd = 0; ok = 0;
        en = rie || eie;
        tr = rx_valid && rx_en && !m_ovr && !fifo_clr;
        seen = m_win || tr;
        if (fifo_clr) begin
            mq.delete();
            m_full = 0; m_ready = 0;
        end else begin
            rd = (pop_cpu || pop_dma) && n > 0;
            ok = tr && (n < DEPTH || rd);
            if (rd) void'(mq.pop_front());
            if (ok) mq.push_back(rx_data);
            if (tr && !ok) everr = 1;
            n2 = mq.size();
            if (ok && n2 >= trig) begin m_full = 1; m_dma = 1; raise = 1; end
            if (rd && pop_dma && n2 < trig) begin
                m_full = 0;
                if (n2 == 0) m_ready = 0;
            end
            if (full_clr && n2 < trig) m_full = 0;
            if (ready_clr && n2 == 0) m_ready = 0;
            if (frame_tick && !seen && !m_prev && n2 > 0 && n2 < trig && !m_ready) begin
                m_ready = 1; m_dma = 1; raise = 1;
            end
        end
        m_ovr = (m_ovr && !ovr_clr) || everr;
        if (frame_tick) begin m_prev = seen; m_win = 0; end
        else m_win = seen;
        m_rirq = (m_rirq || (raise && rie)) && (m_full || m_ready) && rie;
        m_eirq = (m_eirq || (everr && en)) && m_ovr && en;
        @(negedge clk);
        compare_all();
        release_pulses();
    endtask

    task automatic push(input int v);
        rx_valid = 1; rx_data = 8'(v);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rx_en = 1; rie = 0; eie = 0; trig_sel = 0; rx_data = 0;
        release_pulses();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R12";
        compare_all();
        chk("pop_data", int'(pop_data), 0);

        // Every threshold: fill, overflow, frozen strobe, drain, clear overrun
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s); rie = (s % 2 == 0); eie = !rie;
            cur_req = "R9"; fifo_clr = 1; step();
            cur_req = "R2";
            for (int i = 0; i < DEPTH; i++) push(s * 40 + i);
            cur_req = "R3"; push(8'hEE);
            cur_req = "R5"; push(8'hDD);
            cur_req = "R4"; step();
            cur_req = "R1";
            for (int i = 0; i < DEPTH; i++) begin pop_dma = 1; step(); end
            cur_req = "R11"; ovr_clr = 1; step();
            cur_req = "R11"; push(7);
        end

        // Idle-line detection at threshold 4
        trig_sel = 1; rie = 1; eie = 0;
        cur_req = "R9"; fifo_clr = 1; step();
        cur_req = "R6";
        rx_valid = 1; rx_data = 8'h11; frame_tick = 1; step();
        frame_tick = 1; step();
        push(8'h22);
        frame_tick = 1; step();
        frame_tick = 1; step();
        frame_tick = 1; step();
        frame_tick = 1; step();
        cur_req = "R7";  pop_cpu = 1; step();
        cur_req = "R11"; ready_clr = 1; step();
        cur_req = "R7";  pop_dma = 1; step();
        cur_req = "R8";  step();

        // Idle detection with interrupt disabled and at threshold
        rie = 0;
        cur_req = "R6";
        push(1); push(2); push(3);
        for (int i = 0; i < 3; i++) begin frame_tick = 1; step(); end
        push(4);
        for (int i = 0; i < 3; i++) begin frame_tick = 1; step(); end
        cur_req = "R9"; fifo_clr = 1; step();

        // Software clear of threshold flag
        trig_sel = 0; rie = 1;
        cur_req = "R8";  push(8'h5A);
        cur_req = "R11"; full_clr = 1; step();
        cur_req = "R7";  pop_cpu = 1; step();
        cur_req = "R11"; full_clr = 1; step();

        // Pops from empty
        cur_req = "R10"; pop_cpu = 1; step();
        pop_dma = 1; step();
        ready_clr = 1; pop_cpu = 1; step();

        // Receive disabled
        cur_req = "R5"; rx_en = 0; push(8'h77); push(8'h78); rx_en = 1;

        // Reset with contents
        cur_req = "R9"; push(9); push(10); push(11);
        fifo_clr = 1; rx_valid = 1; step();

        // Push and pop together at full occupancy
        trig_sel = 3; eie = 1;
        cur_req = "R1";
        for (int i = 0; i < DEPTH; i++) push(100 + i);
        rx_valid = 1; rx_data = 8'hC3; pop_cpu = 1; step();
        for (int i = 0; i < DEPTH; i++) begin pop_cpu = 1; step(); end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule